// File: doc/BRIEF.md
# Filtered TLP Bandwidth Event Counter

This block observes a stream of received transaction-layer packet descriptors, one per cycle. Each descriptor carries the index of the root port it arrived on, the requester bus/device/function identifier and its payload length in doublewords. A small register interface selects an event class, a target filter, a one-shot length trigger and a length threshold window. Packets that pass every active filter feed a wrapping accumulator. The accumulator adds the packet length for the bandwidth class and adds one per packet for the three counting classes.

Software disables the counter, programs the target and filter words, and then enables it. The enable edge clears the accumulator and the trigger flag. The accumulator, the trigger flag and the configuration error flag can be read back at any time. The target filter has two forms: a bitmap of root ports, or a single requester identifier. Only one form may be in use at a time, and a configuration that breaks this rule raises an error and blocks counting.

Top module: `tlp_bw_counter`

## Requirements
- R1: After reset the accumulator reads 0, the status word reads 0 (bit 0 error, bit 1 trigger armed) and `cfg_err` is low.
- R2: Register 1 bits [15:0] hold the port bitmap. When the bitmap is nonzero, a packet is accepted only if the bitmap bit indexed by `pkt_port` is set. A zero bitmap with the requester filter off accepts every port.
- R3: Control register 0 bits [2:1] select the class: 0 bandwidth, 1 application-layer count, 2 transaction-layer count, 3 data-link count. Several bitmap bits may be set for classes 0 and 1. For classes 2 and 3, more than one set bit raises `cfg_err`, and nothing is counted.
- R4: If the requester filter enable (control bit 3) is set while the port bitmap is nonzero, `cfg_err` is raised and nothing is counted.
- R5: With the requester filter on (compare value in register 1 bits [31:16]), a packet is accepted only when `pkt_rid` equals that value. Using the requester filter with any class other than bandwidth raises `cfg_err`.
- R6: The trigger exponent N sits in register 2 bits [3:0], with mode in bit 4 and enable in bit 5, and the limit is 2^N doublewords. In mode 0 the flag arms on the first target-matching packet strictly longer than the limit. In mode 1 it arms on the first target-matching packet strictly shorter than the limit. Until the flag is armed, nothing is counted.
- R7: The packet that arms the trigger is counted itself if it passes the other filters. The armed flag (status bit 1) then stays set while enabled, and is cleared whenever the counter is disabled.
- R8: The threshold exponent N sits in register 2 bits [11:8], with mode in bit 12 and enable in bit 13. Mode 0 accepts lengths of at least 2^N doublewords, and mode 1 accepts lengths strictly below 2^N.
- R9: For any class other than bandwidth, the trigger and threshold settings have no effect.
- R10: A bandwidth packet adds its doubleword length, and a counting-class packet adds 1. The accumulator is CNT_W bits wide (default 64) and wraps modulo 2^CNT_W. It reads back at register 3 (low word) and register 4 (high word) in the cycle after the packet.
- R11: Setting control bit 0 from 0 to 1 clears the accumulator. While bit 0 is 0, packets are ignored and the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| pkt_valid | input | 1 | Descriptor valid this cycle |
| pkt_port | input | 4 | Root port index of the packet |
| pkt_rid | input | 16 | Requester bus/device/function identifier |
| pkt_len | input | LEN_W | Packet length in doublewords |
| cfg_err | output | 1 | Configuration conflict flag |

## Verification
On every cycle, the assertions check four things. A conflicting target setup always shows up on `cfg_err`. The accumulator stays still in cycles with no packet and no write, and while an error is flagged. The armed flag only rises on a packet cycle, never drops while enabled, and is clear the cycle after a disable. The bench scenarios are the only place where the exact amounts added are shown. The same holds for the strict-versus-inclusive edges of the trigger and threshold compares at exactly 2^N, the bitmap and identifier matches, the wrap of the accumulator, and the clearing on the enable edge.

// File: rtl/tlp_bw_pkg.sv
package tlp_bw_pkg;
  localparam int PORT_W = 4;
  localparam int NPORT  = 1 << PORT_W;
  localparam int EXP_W  = 4;
  localparam int RID_W  = 16;

  typedef enum logic [1:0] {
    EV_BW  = 2'd0,
    EV_APP = 2'd1,
    EV_TL  = 2'd2,
    EV_DL  = 2'd3
  } ev_class_e;

  typedef struct packed {
    logic             en;
    ev_class_e        cls;
    logic             rid_en;
    logic [NPORT-1:0] port_map;
    logic [RID_W-1:0] rid_val;
    logic [EXP_W-1:0] trig_exp;
    logic             trig_mode;
    logic             trig_en;
    logic [EXP_W-1:0] thr_exp;
    logic             thr_mode;
    logic             thr_en;
  } flt_cfg_t;

  // 2^e doublewords
  function automatic logic [31:0] dw_limit(input logic [EXP_W-1:0] e);
    return 32'd1 << e;
  endfunction

  function automatic logic len_below(input logic [31:0] len, input logic [EXP_W-1:0] e);
    return len < dw_limit(e);
  endfunction

  function automatic logic len_above(input logic [31:0] len, input logic [EXP_W-1:0] e);
    return len > dw_limit(e);
  endfunction

  function automatic logic many_bits(input logic [NPORT-1:0] m);
    return (m & (m - 1'b1)) != '0;
  endfunction
endpackage

// File: rtl/tlp_filter_eval.sv
module tlp_filter_eval
  import tlp_bw_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  flt_cfg_t          cfg,
  input  logic [PORT_W-1:0] port,
  input  logic [RID_W-1:0]  rid,
  input  logic [LEN_W-1:0]  len,
  output logic              target_ok,
  output logic              thr_ok,
  output logic              trig_use,
  output logic              trig_hit,
  output logic              cfg_err
);
  logic        is_bw;
  logic        map_used;
  logic        single_only;
  logic [31:0] len32;

  always_comb begin
    len32       = 32'(len);
    is_bw       = (cfg.cls == EV_BW);
    map_used    = |cfg.port_map;
    single_only = (cfg.cls == EV_TL) || (cfg.cls == EV_DL);

    cfg_err = (cfg.rid_en && map_used)
            || (cfg.rid_en && !is_bw)
            || (single_only && many_bits(cfg.port_map));

    if (cfg.rid_en)
      target_ok = (rid == cfg.rid_val);
    else
      target_ok = !map_used || cfg.port_map[port];

    if (is_bw && cfg.thr_en)
      thr_ok = cfg.thr_mode ? len_below(len32, cfg.thr_exp)
                            : !len_below(len32, cfg.thr_exp);
    else
      thr_ok = 1'b1;

    trig_use = is_bw && cfg.trig_en;
    trig_hit = cfg.trig_mode ? len_below(len32, cfg.trig_exp)
                             : len_above(len32, cfg.trig_exp);
  end
endmodule

// File: rtl/tlp_trig_arm.sv
module tlp_trig_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic arm_set,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (!en)    armed <= 1'b0;
    else if (arm_set) armed <= 1'b1;
  end

  // R7: sticky while enabled
  assert_armed_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && en) |=> armed);
  // R7: cleared by disable
  assert_armed_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !armed);
endmodule

// File: rtl/tlp_acc_counter.sv
module tlp_acc_counter #(
  parameter int CNT_W = 64,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [LEN_W-1:0] add_val,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (add_en) cnt <= cnt + CNT_W'(add_val);
  end
endmodule

// File: rtl/tlp_bw_counter.sv
module tlp_bw_counter
  import tlp_bw_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              pkt_valid,
  input  logic [PORT_W-1:0] pkt_port,
  input  logic [RID_W-1:0]  pkt_rid,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic              cfg_err
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TGT  = 3'd1;
  localparam logic [2:0] A_FLT  = 3'd2;
  localparam logic [2:0] A_CLO  = 3'd3;
  localparam logic [2:0] A_CHI  = 3'd4;
  localparam logic [2:0] A_STS  = 3'd5;

  logic [31:0]      ctrl_q, tgt_q, flt_q;
  flt_cfg_t         cfg;
  logic             target_ok, thr_ok, trig_use, trig_hit;
  logic             armed, arm_set, accept, en_rise;
  logic [LEN_W-1:0] step;
  logic [CNT_W-1:0] cnt;
  logic [63:0]      cnt_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tgt_q  <= '0;
      flt_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_CTRL:  ctrl_q <= cfg_wdata;
        A_TGT:   tgt_q  <= cfg_wdata;
        A_FLT:   flt_q  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg.en        = ctrl_q[0];
    cfg.cls       = ev_class_e'(ctrl_q[2:1]);
    cfg.rid_en    = ctrl_q[3];
    cfg.port_map  = tgt_q[15:0];
    cfg.rid_val   = tgt_q[31:16];
    cfg.trig_exp  = flt_q[3:0];
    cfg.trig_mode = flt_q[4];
    cfg.trig_en   = flt_q[5];
    cfg.thr_exp   = flt_q[11:8];
    cfg.thr_mode  = flt_q[12];
    cfg.thr_en    = flt_q[13];
  end

  tlp_filter_eval #(.LEN_W(LEN_W)) u_eval (
    .cfg(cfg), .port(pkt_port), .rid(pkt_rid), .len(pkt_len),
    .target_ok(target_ok), .thr_ok(thr_ok), .trig_use(trig_use),
    .trig_hit(trig_hit), .cfg_err(cfg_err)
  );

  assign arm_set = pkt_valid && cfg.en && !cfg_err && trig_use && target_ok && trig_hit;
  assign accept  = pkt_valid && cfg.en && !cfg_err && target_ok && thr_ok
                 && (!trig_use || armed || trig_hit);
  assign en_rise = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[0] && !ctrl_q[0];
  assign step    = (cfg.cls == EV_BW) ? pkt_len : LEN_W'(1);

  tlp_trig_arm u_arm (
    .clk(clk), .rst_n(rst_n), .en(cfg.en), .arm_set(arm_set), .armed(armed)
  );

  tlp_acc_counter #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(en_rise), .add_en(accept),
    .add_val(step), .cnt(cnt)
  );

  always_comb begin
    cnt_ext = '0;
    cnt_ext[CNT_W-1:0] = cnt;
    case (cfg_addr)
      A_CTRL:  cfg_rdata = ctrl_q;
      A_TGT:   cfg_rdata = tgt_q;
      A_FLT:   cfg_rdata = flt_q;
      A_CLO:   cfg_rdata = cnt_ext[31:0];
      A_CHI:   cfg_rdata = cnt_ext[63:32];
      A_STS:   cfg_rdata = {30'd0, armed, cfg_err};
      default: cfg_rdata = '0;
    endcase
  end

  // R4: both target forms active must be flagged
  assert_target_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[3] && (tgt_q[15:0] != '0)) |-> cfg_err);
  // R3: an error blocks all counting
  assert_err_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !cfg_we) |=> $stable(cnt));
  // R11: no packet and no write leaves the accumulator unchanged
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_valid && !cfg_we) |=> $stable(cnt));
  // R6: the trigger only arms on a packet cycle
  assert_arm_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(pkt_valid));
endmodule

// File: tb/tlp_bw_counter_test.sv
module tlp_bw_counter_test;
  localparam int CLK_P = 10;
  localparam int CW    = 16;
  localparam int LW    = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          pkt_valid = 1'b0;
  logic [3:0]    pkt_port = '0;
  logic [15:0]   pkt_rid = '0;
  logic [LW-1:0] pkt_len = '0;
  logic          cfg_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  tlp_bw_counter #(.CNT_W(CW), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pkt_valid(pkt_valid),
    .pkt_port(pkt_port), .pkt_rid(pkt_rid), .pkt_len(pkt_len), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] tgt;
    logic [31:0] flt;
    logic [3:0]  port;
    logic [15:0] rid;
    logic [10:0] len;
    logic [31:0] exp_cnt;
    logic        exp_err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{32'h1, 32'h0,          32'h0,    4'd3, 16'h0,    11'd20, 32'd20, 1'b0, 8'd10}, // R10 bw
    '{32'h3, 32'h0,          32'h0,    4'd3, 16'h0,    11'd20, 32'd1,  1'b0, 8'd10}, // R10 count
    '{32'h1, 32'h0101,       32'h0,    4'd8, 16'h0,    11'd7,  32'd7,  1'b0, 8'd2},  // R2 hit
    '{32'h1, 32'h0101,       32'h0,    4'd4, 16'h0,    11'd7,  32'd0,  1'b0, 8'd2},  // R2 miss
    '{32'h3, 32'h0101,       32'h0,    4'd0, 16'h0,    11'd5,  32'd1,  1'b0, 8'd3},  // R3 multi ok
    '{32'h5, 32'h0101,       32'h0,    4'd0, 16'h0,    11'd5,  32'd0,  1'b1, 8'd3},  // R3 multi bad
    '{32'h7, 32'h0100,       32'h0,    4'd8, 16'h0,    11'd5,  32'd1,  1'b0, 8'd3},  // R3 single ok
    '{32'h9, 32'h3900_0000,  32'h0,    4'd2, 16'h3900, 11'd9,  32'd9,  1'b0, 8'd5},  // R5 match
    '{32'h9, 32'h3900_0000,  32'h0,    4'd2, 16'h3901, 11'd9,  32'd0,  1'b0, 8'd5},  // R5 miss
    '{32'h9, 32'h3900_0001,  32'h0,    4'd0, 16'h3900, 11'd9,  32'd0,  1'b1, 8'd4},  // R4
    '{32'hB, 32'h3900_0000,  32'h0,    4'd0, 16'h3900, 11'd9,  32'd0,  1'b1, 8'd5},  // R5 class
    '{32'h1, 32'h0,          32'h2400, 4'd0, 16'h0,    11'd16, 32'd16, 1'b0, 8'd8},  // R8
    '{32'h1, 32'h0,          32'h2400, 4'd0, 16'h0,    11'd15, 32'd0,  1'b0, 8'd8},  // R8
    '{32'h1, 32'h0,          32'h3400, 4'd0, 16'h0,    11'd15, 32'd15, 1'b0, 8'd8},  // R8
    '{32'h1, 32'h0,          32'h3400, 4'd0, 16'h0,    11'd16, 32'd0,  1'b0, 8'd8},  // R8
    '{32'h3, 32'h0,          32'h2400, 4'd0, 16'h0,    11'd3,  32'd1,  1'b0, 8'd9},  // R9
    '{32'h3, 32'h0,          32'h24,   4'd0, 16'h0,    11'd3,  32'd1,  1'b0, 8'd9},  // R9
    '{32'h1, 32'h0,          32'h24,   4'd0, 16'h0,    11'd17, 32'd17, 1'b0, 8'd7},  // R7 R6
    '{32'h1, 32'h0,          32'h24,   4'd0, 16'h0,    11'd16, 32'd0,  1'b0, 8'd6},  // R6
    '{32'h1, 32'h0,          32'h34,   4'd0, 16'h0,    11'd15, 32'd15, 1'b0, 8'd6},  // R6
    '{32'h1, 32'h0,          32'h34,   4'd0, 16'h0,    11'd16, 32'd0,  1'b0, 8'd6}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic pkt(input logic [3:0] p, input logic [15:0] r, input logic [10:0] l);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_port = p; pkt_rid = r; pkt_len = l;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic setup(input logic [31:0] c, input logic [31:0] t, input logic [31:0] f);
    wr(3'd0, 32'h0);
    wr(3'd1, t);
    wr(3'd2, f);
    wr(3'd0, c);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd3, d); check("R1 cnt_lo", d, 32'd0);
    rd(3'd5, d); check("R1 status", d, 32'd0);
    check("R1 cfg_err", {31'd0, cfg_err}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      setup(VEC[i].ctrl, VEC[i].tgt, VEC[i].flt);
      check($sformatf("R%0d err vec%0d", VEC[i].req, i), {31'd0, cfg_err}, {31'd0, VEC[i].exp_err});
      pkt(VEC[i].port, VEC[i].rid, VEC[i].len);
      rd(3'd3, d);
      check($sformatf("R%0d cnt vec%0d", VEC[i].req, i), d, VEC[i].exp_cnt);
    end

    // R6 R7: trigger mode 0 with limit 8, sticky after arming
    setup(32'h1, 32'h0, 32'h23);
    pkt(4'd0, 16'h0, 11'd4);
    pkt(4'd0, 16'h0, 11'd8);
    rd(3'd5, d); check("R6 not armed at limit", d, 32'd0);
    rd(3'd3, d); check("R6 nothing before trigger", d, 32'd0);
    pkt(4'd0, 16'h0, 11'd9);
    pkt(4'd0, 16'h0, 11'd2);
    rd(3'd3, d); check("R7 trigger pkt and later pkt", d, 32'd11);
    rd(3'd5, d); check("R7 armed", d, 32'd2);

    // R11 disable holds count, clears armed, ignores packets
    wr(3'd0, 32'h0);
    pkt(4'd0, 16'h0, 11'd50);
    rd(3'd3, d); check("R11 hold while disabled", d, 32'd11);
    rd(3'd5, d); check("R7 armed cleared on disable", d, 32'd0);
    wr(3'd0, 32'h1);
    rd(3'd3, d); check("R11 cleared on enable", d, 32'd0);

    // R6 trigger ignores packets that miss the target
    setup(32'h1, 32'h0002, 32'h23);
    pkt(4'd2, 16'h0, 11'd100);
    rd(3'd5, d); check("R6 off-target no arm", d, 32'd0);
    pkt(4'd1, 16'h0, 11'd100);
    rd(3'd3, d); check("R6 on-target arms", d, 32'd100);

    // R10 wrap of a 16-bit accumulator
    setup(32'h1, 32'h0, 32'h0);
    for (int k = 0; k < 64; k++) pkt(4'd0, 16'h0, 11'd1024);
    pkt(4'd0, 16'h0, 11'd5);
    rd(3'd3, d); check("R10 wrap low", d, 32'd5);
    rd(3'd4, d); check("R10 wrap high", d, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule